// File: doc/BRIEF.md
# I2C Slave Controller with Status Flags

This block is an I2C slave for a processor subsystem. On the bus side, SCL and SDA are sampled on the system clock, and START and STOP conditions are detected. The block matches a programmable 7-bit address and records the read/write bit. It receives bytes with an ACK, or sends bytes MSB first until the master NACKs. SDA is an open-drain pin. The block only enables a pull-down through `sda_oe` and never drives the line high.

On the processor side there are four word-wide registers. One is the received byte and one is the byte to transmit. One is a read-only access status word. The fourth is a control word that holds the own address, three interrupt enables and the stop-detected flag. The status flags change as side effects of processor accesses. Reading the receive register clears receive-ready. Writing the transmit register clears transmit-empty. Writing 1 to the stop flag bit clears that flag. A single level interrupt reports the enabled flags that are set.

Top module: `i2c_slave_status`

## Requirements
- R1: The status word at offset 2 holds receive-ready in bit 4, transmit-empty in bit 3, bus-busy in bit 2, selected in bit 1 and direction in bit 0. Bits 15..5 read 0, and writes to offset 2 have no effect.
- R2: After reset, every status bit, the control word and `irq` are 0, and `sda_oe` is 0.
- R3: Receive-ready rises when a received byte is loaded into the receive register (offset 0, byte in bits 7..0). A read of offset 0 clears it.
- R4: Transmit-empty rises once the 8th bit of the byte from the transmit register (offset 1) has been clocked out. A write to offset 1 clears it.
- R5: Bus-busy is set by a START or by either line being sampled low, whether or not the address matches. Only a STOP clears it.
- R6: A match between the received address and control bits 6..0 sets selected and is ACKed. A mismatch is not ACKed and leaves selected at 0. A STOP clears selected.
- R7: The direction bit holds the R/W bit received with a matching address: 1 means the master reads, 0 means the master writes. The bit keeps its value after STOP.
- R8: The stop flag (control bit 15) is set by a STOP that ends an access while the block is selected. Only writing 1 to bit 15 clears it, and writing 0 leaves it unchanged.
- R9: `irq` is the OR of the set flags whose enables are on. The enables are control bit 8 for receive-ready, bit 9 for transmit-empty and bit 10 for the stop flag.
- R10: Every received data byte is ACKed. In a master-read transfer the block drives the data MSB first and reloads from the transmit register after each master ACK. On a NACK it releases SDA and goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 pulls SDA low |
| cpu_addr | input | 2 | Register offset: 0 receive, 1 transmit, 2 status, 3 control |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for `cpu_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
A bus event acts on internal state no more than three clock edges after the pin changes: two synchroniser stages, then the register that acts on the detected edge. The bench therefore holds each SCL phase for ten clocks and samples the status only after a bit or byte has completed. A processor access changes its flag at the clock edge that ends the strobe cycle. Reads are compared two nanoseconds after the falling edge that starts the strobe, so the word seen is the value before that access takes effect. `irq` and `sda_oe` are checked at least one full clock after the access or bus phase that should change them.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int REG_W  = 16;
    localparam int OFS_W  = 2;

    localparam logic [OFS_W-1:0] OFS_RX   = 2'd0;
    localparam logic [OFS_W-1:0] OFS_TX   = 2'd1;
    localparam logic [OFS_W-1:0] OFS_STAT = 2'd2;
    localparam logic [OFS_W-1:0] OFS_CTRL = 2'd3;

    // control word field positions
    localparam int CTRL_IE_RX   = 8;
    localparam int CTRL_IE_TX   = 9;
    localparam int CTRL_IE_STOP = 10;
    localparam int CTRL_STOPF   = 15;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ACK,
        LK_RX,
        LK_TX,
        LK_TXACK,
        LK_TXNEXT
    } link_st_e;

    // packed order gives the status bit positions 4..0
    typedef struct packed {
        logic rx_ready;
        logic tx_empty;
        logic busy;
        logic selected;
        logic dir;
    } status_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [REG_W-1:0] pack_status(status_t s);
        return {{(REG_W - $bits(status_t)){1'b0}}, s};
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_sr, sda_sr;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s = scl_sr[STAGES-1];
    assign sda_s = sda_sr[STAGES-1];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cs_link.sv
module i2cs_link
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_load,
    output logic              tx_done,
    output logic              sel_set,
    output logic              dir
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    link_st_e          st;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg, txsh, shift_in;
    logic              ack_drv;

    assign shift_in = {shreg[DATA_W-2:0], ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= LK_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            txsh    <= '0;
            ack_drv <= 1'b0;
            sda_oe  <= 1'b0;
            rx_byte <= '0;
            rx_load <= 1'b0;
            tx_done <= 1'b0;
            sel_set <= 1'b0;
            dir     <= 1'b0;
        end else begin
            rx_load <= 1'b0;
            tx_done <= 1'b0;
            sel_set <= 1'b0;
            if (ev.stop) begin
                st     <= LK_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                st     <= LK_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    LK_ADDR: if (ev.scl_rise) begin
                        shreg <= shift_in;
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            if (shift_in[DATA_W-1:1] == own_addr) begin
                                sel_set <= 1'b1;
                                dir     <= shift_in[0];
                                ack_drv <= 1'b0;
                                st      <= LK_ACK;
                            end else begin
                                st <= LK_IDLE;
                            end
                        end
                    end
                    LK_ACK: if (ev.scl_fall) begin
                        if (!ack_drv) begin
                            sda_oe  <= 1'b1;
                            ack_drv <= 1'b1;
                        end else begin
                            ack_drv <= 1'b0;
                            cnt     <= '0;
                            if (dir) begin
                                st     <= LK_TX;
                                txsh   <= tx_byte;
                                sda_oe <= ~tx_byte[DATA_W-1];
                            end else begin
                                st     <= LK_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    LK_RX: if (ev.scl_rise) begin
                        shreg <= shift_in;
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            rx_byte <= shift_in;
                            rx_load <= 1'b1;
                            ack_drv <= 1'b0;
                            st      <= LK_ACK;
                        end
                    end
                    LK_TX: begin
                        if (ev.scl_rise) begin
                            txsh <= txsh << 1;
                            cnt  <= cnt + 1'b1;
                            if (cnt == LAST) tx_done <= 1'b1;
                        end else if (ev.scl_fall) begin
                            if (cnt == FULL) begin
                                sda_oe <= 1'b0;
                                st     <= LK_TXACK;
                            end else begin
                                sda_oe <= ~txsh[DATA_W-1];
                            end
                        end
                    end
                    LK_TXACK: if (ev.scl_rise) begin
                        st <= ev.sda ? LK_IDLE : LK_TXNEXT;
                    end
                    LK_TXNEXT: if (ev.scl_fall) begin
                        st     <= LK_TX;
                        cnt    <= '0;
                        txsh   <= tx_byte;
                        sda_oe <= ~tx_byte[DATA_W-1];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cs_cpu_regs.sv
module i2cs_cpu_regs
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    output logic              irq,
    input  bus_ev_t           ev,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_load,
    input  logic              tx_done,
    input  logic              sel_set,
    input  logic              dir,
    output logic [ADDR_W-1:0] own_addr,
    output logic [DATA_W-1:0] tx_byte,
    output status_t           stat,
    output logic              stop_flag
);
    logic ie_rx, ie_tx, ie_stop;
    logic rd_rx, wr_tx, wr_ctrl;

    assign rd_rx   = cpu_rd && (cpu_addr == OFS_RX);
    assign wr_tx   = cpu_wr && (cpu_addr == OFS_TX);
    assign wr_ctrl = cpu_wr && (cpu_addr == OFS_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat      <= '0;
            stop_flag <= 1'b0;
            own_addr  <= '0;
            tx_byte   <= '0;
            ie_rx     <= 1'b0;
            ie_tx     <= 1'b0;
            ie_stop   <= 1'b0;
        end else begin
            if (rx_load)    stat.rx_ready <= 1'b1;
            else if (rd_rx) stat.rx_ready <= 1'b0;

            if (tx_done)    stat.tx_empty <= 1'b1;
            else if (wr_tx) stat.tx_empty <= 1'b0;

            if (ev.stop) stat.busy <= 1'b0;
            else if (ev.start || !ev.scl || !ev.sda) stat.busy <= 1'b1;

            if (ev.stop)      stat.selected <= 1'b0;
            else if (sel_set) stat.selected <= 1'b1;

            stat.dir <= dir;

            if (ev.stop && stat.selected) stop_flag <= 1'b1;
            else if (wr_ctrl && cpu_wdata[CTRL_STOPF]) stop_flag <= 1'b0;

            if (wr_tx) tx_byte <= cpu_wdata[DATA_W-1:0];
            if (wr_ctrl) begin
                own_addr <= cpu_wdata[ADDR_W-1:0];
                ie_rx    <= cpu_wdata[CTRL_IE_RX];
                ie_tx    <= cpu_wdata[CTRL_IE_TX];
                ie_stop  <= cpu_wdata[CTRL_IE_STOP];
            end
        end
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            OFS_RX:   cpu_rdata[DATA_W-1:0] = rx_byte;
            OFS_TX:   cpu_rdata[DATA_W-1:0] = tx_byte;
            OFS_STAT: cpu_rdata = pack_status(stat);
            default: begin
                cpu_rdata[ADDR_W-1:0]   = own_addr;
                cpu_rdata[CTRL_IE_RX]   = ie_rx;
                cpu_rdata[CTRL_IE_TX]   = ie_tx;
                cpu_rdata[CTRL_IE_STOP] = ie_stop;
                cpu_rdata[CTRL_STOPF]   = stop_flag;
            end
        endcase
    end

    assign irq = (stat.rx_ready & ie_rx) | (stat.tx_empty & ie_tx) | (stop_flag & ie_stop);
endmodule

// File: rtl/i2c_slave_status.sv
module i2c_slave_status
    import i2cs_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [1:0]  cpu_addr,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [15:0] cpu_wdata,
    output logic [15:0] cpu_rdata,
    output logic        irq
);
    bus_ev_t           ev;
    status_t           stat;
    logic              stop_flag;
    logic [DATA_W-1:0] rx_byte, tx_byte;
    logic [ADDR_W-1:0] own_addr;
    logic              rx_load, tx_done, sel_set, dir;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cs_link #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_link (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .own_addr (own_addr),
        .tx_byte  (tx_byte),
        .sda_oe   (sda_oe),
        .rx_byte  (rx_byte),
        .rx_load  (rx_load),
        .tx_done  (tx_done),
        .sel_set  (sel_set),
        .dir      (dir)
    );

    i2cs_cpu_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .irq       (irq),
        .ev        (ev),
        .rx_byte   (rx_byte),
        .rx_load   (rx_load),
        .tx_done   (tx_done),
        .sel_set   (sel_set),
        .dir       (dir),
        .own_addr  (own_addr),
        .tx_byte   (tx_byte),
        .stat      (stat),
        .stop_flag (stop_flag)
    );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [1:0]  cpu_addr,
    input logic        cpu_wr,
    input logic        cpu_rd,
    input logic [15:0] cpu_wdata,
    input logic [15:0] cpu_rdata,
    input logic        irq,
    input status_t     stat,
    input logic        stop_flag,
    input logic        rx_load,
    input logic        tx_done,
    input bus_ev_t     ev
);
    assert_stat_reserved_R1: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr == OFS_STAT) |-> (cpu_rdata[15:5] == 11'd0));

    assert_rx_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && cpu_addr == OFS_RX && !rx_load) |=> !stat.rx_ready);

    assert_tx_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == OFS_TX && !tx_done) |=> !stat.tx_empty);

    assert_busy_start_R5: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> stat.busy);

    assert_sel_stop_R6: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !stat.selected);

    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (stop_flag && !(cpu_wr && cpu_addr == OFS_CTRL && cpu_wdata[CTRL_STOPF])) |=> stop_flag);

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!stat.rx_ready && !stat.tx_empty && !stop_flag) |-> !irq);
endmodule

bind i2c_slave_status i2cs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .irq       (irq),
    .stat      (stat),
    .stop_flag (stop_flag),
    .rx_load   (rx_load),
    .tx_done   (tx_done),
    .ev        (ev)
);

// File: tb/test_i2c_slave_status.sv
`timescale 1ns/1ps
module test_i2c_slave_status;
    localparam int PH = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        sda_oe;
    logic [1:0]  cpu_addr = 2'd0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [15:0] cpu_wdata = 16'd0;
    logic [15:0] cpu_rdata;
    logic        irq;
    logic        sda_line;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_slave_status i_i2c_slave_status (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .irq       (irq)
    );

    // monitor: compares each read against the queued expectation
    always @(negedge clk) begin
        #2;
        if (cpu_rd && exp_q.size() > 0) begin
            logic [15:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (cpu_rdata !== e) begin
                bad++;
                $display("FAIL %s: rdata actual=%h expected=%h", t, cpu_rdata, e);
            end
        end
    end

    task automatic chk(input string t, input logic [15:0] act, input logic [15:0] e);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", t, act, e);
        end
    endtask

    task automatic rd_exp(input logic [1:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        cpu_addr = a;
        cpu_rd   = 1'b1;
        @(negedge clk);
        cpu_rd   = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        @(negedge clk);
        cpu_wr    = 1'b0;
        @(negedge clk);
    endtask

    task automatic ph();
        repeat (PH) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; ph();
        sda_m = 1'b0; ph();
        scl_m = 1'b0; ph();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; ph();
        scl_m = 1'b1; ph();
        sda_m = 1'b1; ph();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; ph();
        scl_m = 1'b1; ph();
        scl_m = 1'b0; ph();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; ph();
        scl_m = 1'b1;
        repeat (PH/2) @(negedge clk);
        b = sda_line;
        repeat (PH/2) @(negedge clk);
        scl_m = 1'b0; ph();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(ack);
    endtask

    task automatic recv_bits(output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            d[i] = b;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] b;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2 reset state
        rd_exp(2'd2, 16'h0000, "R2 status after reset");
        rd_exp(2'd3, 16'h0000, "R2 control after reset");
        chk("R2 irq after reset", {15'd0, irq}, 16'd0);
        chk("R2 sda_oe after reset", {15'd0, sda_oe}, 16'd0);

        // R1 status is read-only
        wr(2'd2, 16'hFFFF);
        rd_exp(2'd2, 16'h0000, "R1 write to status ignored");

        // R5 busy from a line going low, cleared only by STOP
        scl_m = 1'b0; ph();
        rd_exp(2'd2, 16'h0004, "R5 busy on SCL low");
        scl_m = 1'b1; ph();
        rd_exp(2'd2, 16'h0004, "R5 busy held without STOP");
        sda_m = 1'b0; ph();
        sda_m = 1'b1; ph();
        rd_exp(2'd2, 16'h0000, "R5 busy cleared by STOP");
        rd_exp(2'd3, 16'h0000, "R8 no stop flag when unselected");

        // R6 address mismatch
        wr(2'd3, 16'h002A);
        rd_exp(2'd3, 16'h002A, "R6 own address programmed");
        bus_start();
        send_byte({7'h15, 1'b0}, ack);
        chk("R6 mismatch not acked", {15'd0, ack}, 16'd1);
        rd_exp(2'd2, 16'h0004, "R5 busy while other slave addressed");
        send_byte(8'h55, ack);
        chk("R6 data to other slave not acked", {15'd0, ack}, 16'd1);
        bus_stop();
        rd_exp(2'd2, 16'h0000, "R6 still unselected after STOP");
        rd_exp(2'd3, 16'h002A, "R8 stop flag stays 0 for foreign access");

        // master write transfer
        wr(2'd3, 16'h012A);
        bus_start();
        send_byte({7'h2A, 1'b0}, ack);
        chk("R6 matching address acked", {15'd0, ack}, 16'd0);
        rd_exp(2'd2, 16'h0006, "R7 selected, direction write");
        chk("R9 irq idle before data", {15'd0, irq}, 16'd0);
        send_byte(8'hA5, ack);
        chk("R10 data byte acked", {15'd0, ack}, 16'd0);
        rd_exp(2'd2, 16'h0016, "R3 rx ready set");
        chk("R9 irq from rx ready", {15'd0, irq}, 16'd1);
        rd_exp(2'd0, 16'h00A5, "R3 received byte");
        rd_exp(2'd2, 16'h0006, "R3 rx ready cleared by read");
        chk("R9 irq drops after read", {15'd0, irq}, 16'd0);
        send_byte(8'h3C, ack);
        chk("R10 second byte acked", {15'd0, ack}, 16'd0);
        rd_exp(2'd0, 16'h003C, "R3 second received byte");
        rd_exp(2'd2, 16'h0006, "R3 cleared after second read");
        bus_stop();
        rd_exp(2'd2, 16'h0000, "R6 selected cleared by STOP");
        rd_exp(2'd3, 16'h812A, "R8 stop flag set");
        chk("R9 stop flag masked", {15'd0, irq}, 16'd0);
        wr(2'd3, 16'h052A);
        chk("R9 irq from stop flag", {15'd0, irq}, 16'd1);
        rd_exp(2'd3, 16'h852A, "R8 writing 0 keeps flag");
        wr(2'd3, 16'h852A);
        rd_exp(2'd3, 16'h052A, "R8 writing 1 clears flag");
        chk("R9 irq drops after stop clear", {15'd0, irq}, 16'd0);

        // master read transfer
        wr(2'd1, 16'h0096);
        wr(2'd3, 16'h022A);
        bus_start();
        send_byte({7'h2A, 1'b1}, ack);
        chk("R6 read address acked", {15'd0, ack}, 16'd0);
        rd_exp(2'd2, 16'h0007, "R7 direction read");
        chk("R9 tx empty not yet set", {15'd0, irq}, 16'd0);
        recv_bits(b);
        chk("R10 first transmitted byte", {8'd0, b}, 16'h0096);
        rd_exp(2'd2, 16'h000F, "R4 tx empty after byte");
        chk("R9 irq from tx empty", {15'd0, irq}, 16'd1);
        wr(2'd1, 16'h005B);
        rd_exp(2'd2, 16'h0007, "R4 tx empty cleared by write");
        chk("R9 irq drops after tx write", {15'd0, irq}, 16'd0);
        put_bit(1'b0);
        recv_bits(b);
        chk("R10 reloaded byte after ACK", {8'd0, b}, 16'h005B);
        put_bit(1'b1);
        repeat (3) @(negedge clk);
        chk("R10 SDA released after NACK", {15'd0, sda_oe}, 16'd0);
        rd_exp(2'd2, 16'h000F, "R4 tx empty after last byte");
        bus_stop();
        rd_exp(2'd2, 16'h0009, "R7 direction kept after STOP");
        rd_exp(2'd3, 16'h822A, "R8 stop flag after read access");
        chk("R9 irq tx empty enabled", {15'd0, irq}, 16'd1);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule